// File: doc/BRIEF.md
# Slave Synchronous Serial Port

This block is a slave serial port that moves fixed-length words in both directions over one externally supplied bit clock and one externally supplied frame sync. A rising frame sync, seen at a rising bit-clock edge, starts a word. The bit sampled at that edge is the first, most significant bit. Once the programmed number of bits has arrived, the receive shift register is copied in parallel into a receive data register. At the same word start, a transmit holding register is copied into a transmit shift register and sent MSB first.

There are two framing modes. In normal mode each frame sync carries exactly one word, and any bit clocks after that word are ignored. In network mode words follow one another with no gap, and a packet ends only when the next rising frame sync arrives. A tag shows whether a received word was the one that came with the sync. A small register bus configures the port, loads transmit words and reads received words. Two level interrupts report a waiting receive word and a free transmit holding register. While the port is enabled it takes over one shared receive pin and one shared transmit pin from a neighbouring audio port. While it is disabled those pins pass through to the audio port.

The system clock `clk` samples the bit clock, frame sync and data. The bit clock must stay high and low for at least two system clocks each.

Top module: `ssp_slave`

## Requirements
- R1: After reset, CTRL (address 0) reads 0 and STATUS (address 3) reads 2. STATUS holds rx_full in bit 0, tx_empty in bit 1 and the word tag in bit 2. Both irq_rx and irq_tx are low.
- R2: CTRL bits [3:2] select the word length: 00 gives 8 bits, 01 gives 16 bits, 10 or 11 gives 24 bits. A received word sits right-aligned in RXDATA (address 2), and all bits above the word length read 0.
- R3: Receive bits are sampled on rising bit-clock edges. A word starts at a rising edge where frame sync is high after having been low at the previous rising edge, and the bit sampled at that edge is the word's MSB.
- R4: When the last bit of a word is sampled, RXDATA is loaded and STATUS bit 0 and irq_rx go high. They stay high until RXDATA is read.
- R5: In normal mode (CTRL bit 1 = 0), bit clocks after a completed word load nothing until the next rising frame sync.
- R6: In network mode (CTRL bit 1 = 1), a new word starts on the edge right after the previous word completes. STATUS bit 2 reads 1 for a word that began with a frame sync and 0 for the other words of the packet. In normal mode STATUS bit 2 always reads 0.
- R7: A rising frame sync in the middle of a word discards the partial word, and that edge becomes the first bit of a new word.
- R8: A word written to TXDATA (address 1) moves to the shifter at the next word start, and the low word-length bits are sent MSB first. pin_tx_o changes only after rising bit-clock edges, so the far end reads bit k at rising edge k+1, counting the word-start edge as edge 0. The move sets STATUS bit 1, and sets irq_tx while the port is enabled. A TXDATA write clears both.
- R9: If the holding register is empty at a word start, the port sends zeros for that word.
- R10: With CTRL bit 0 = 0, pin_tx_o follows aud_txd_i, aud_rxd_o follows pin_rx_i, and no word is received. With CTRL bit 0 = 1, aud_rxd_o is 0 and pin_tx_o carries port data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for clear on read) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for the addressed register |
| irq_rx | output | 1 | Receive word waiting |
| irq_tx | output | 1 | Transmit holding register free (port enabled) |
| sck_i | input | 1 | Serial bit clock from the master |
| fs_i | input | 1 | Frame sync from the master |
| pin_rx_i | input | 1 | Shared serial receive pin |
| pin_tx_o | output | 1 | Shared serial transmit pin |
| aud_txd_i | input | 1 | Audio port transmit data for the shared pin |
| aud_rxd_o | output | 1 | Shared receive pin passed on to the audio port |

## Verification
The hardest case to reach is a network-mode packet in which the transmit holding register has to be refilled while the current word is still shifting. In the same packet the tag must drop after the first word. The stimulus gets there by driving bit-clock cycles one at a time. After each word-start edge it writes the next transmit word, and after each completing edge it reads STATUS and RXDATA. It then checks all three received words and a 24-sample stream of transmitted bits that crosses the word boundaries. A frame sync injected partway through a word covers the restart case.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int WORD_W = 24;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_TXDATA = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_RXDATA = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd3;

    // word length selected by a 2-bit code
    function automatic int unsigned len_bits(input logic [1:0] code);
        case (code)
            2'd0:    len_bits = 8;
            2'd1:    len_bits = 16;
            default: len_bits = 24;
        endcase
    endfunction
endpackage

// File: rtl/ssp_edge.sv
module ssp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic fs_i,
    output logic bit_evt_o,
    output logic frame_evt_o
);
    typedef struct packed {
        logic sck;
        logic fs_prev;
    } edge_st_t;

    edge_st_t q, d;

    always_comb begin
        d         = q;
        bit_evt_o = sck_i & ~q.sck;
        frame_evt_o = bit_evt_o & fs_i & ~q.fs_prev;
        d.sck     = sck_i;
        if (bit_evt_o) begin
            d.fs_prev = fs_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift
    import ssp_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              net_i,
    input  logic [1:0]        len_i,
    input  logic              bit_evt_i,
    input  logic              frame_evt_i,
    input  logic              rxd_i,
    input  logic [DATA_W-1:0] tx_hold_i,
    input  logic              tx_full_i,
    output logic              txd_o,
    output logic              rx_load_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              rx_tag_o,
    output logic              tx_take_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DATA_W);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rxsh;
        logic [DATA_W-1:0] txsh;
        logic              tag;
    } shift_st_t;

    shift_st_t q, d;

    logic [CNT_W-1:0]  wlen;
    logic [CNT_W-1:0]  shamt;
    logic [DATA_W-1:0] len_mask;
    logic [DATA_W-1:0] rx_shifted;
    logic              word_begin;

    always_comb begin
        wlen     = CNT_W'(len_bits(len_i));
        shamt    = CNT_TOP - wlen;
        len_mask = ~({DATA_W{1'b1}} << wlen);
    end

    always_comb begin
        d          = q;
        rx_load_o  = 1'b0;
        tx_take_o  = 1'b0;
        rx_shifted = {q.rxsh[DATA_W-2:0], rxd_i};
        word_begin = frame_evt_i || (q.active && (q.cnt == '0));
        if (!en_i) begin
            d.active = 1'b0;
            d.cnt    = '0;
            d.txsh   = '0;
            d.tag    = 1'b0;
        end else if (bit_evt_i) begin
            d.txsh = q.txsh << 1;
            if (word_begin) begin
                d.active  = 1'b1;
                d.cnt     = CNT_ONE;
                d.rxsh    = rx_shifted;
                d.tag     = frame_evt_i & net_i;
                tx_take_o = 1'b1;
                d.txsh    = tx_full_i ? (tx_hold_i << shamt) : '0;
            end else if (q.active) begin
                d.rxsh = rx_shifted;
                d.cnt  = q.cnt + CNT_ONE;
                if ((q.cnt + CNT_ONE) == wlen) begin
                    rx_load_o = 1'b1;
                    d.cnt     = '0;
                    d.active  = net_i;
                end
            end
        end
        rx_word_o = rx_shifted & len_mask;
        rx_tag_o  = q.tag;
        txd_o     = q.txsh[DATA_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
    import ssp_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_load_i,
    input  logic [DATA_W-1:0] rx_word_i,
    input  logic              rx_tag_i,
    input  logic              tx_take_i,
    output logic              en_o,
    output logic              net_o,
    output logic [1:0]        len_o,
    output logic [DATA_W-1:0] tx_hold_o,
    output logic              tx_full_o,
    output logic              irq_rx,
    output logic              irq_tx
);
    typedef struct packed {
        logic              en;
        logic              net;
        logic [1:0]        len;
        logic [DATA_W-1:0] hold;
        logic              tx_full;
        logic [DATA_W-1:0] rx;
        logic              rx_full;
        logic              tag;
    } reg_st_t;

    reg_st_t q, d;

    always_comb begin
        d = q;
        if (tx_take_i) begin
            d.tx_full = 1'b0;
        end
        if (bus_wr && bus_addr == ADR_TXDATA) begin
            d.hold    = bus_wdata;
            d.tx_full = 1'b1;
        end
        if (bus_wr && bus_addr == ADR_CTRL) begin
            d.en  = bus_wdata[0];
            d.net = bus_wdata[1];
            d.len = bus_wdata[3:2];
        end
        if (bus_rd && bus_addr == ADR_RXDATA) begin
            d.rx_full = 1'b0;
        end
        if (rx_load_i) begin
            d.rx      = rx_word_i;
            d.rx_full = 1'b1;
            d.tag     = rx_tag_i;
        end
    end

    always_comb begin
        case (bus_addr)
            ADR_CTRL:   bus_rdata = {{(DATA_W-4){1'b0}}, q.len, q.net, q.en};
            ADR_RXDATA: bus_rdata = q.rx;
            ADR_STATUS: bus_rdata = {{(DATA_W-3){1'b0}}, q.tag, ~q.tx_full, q.rx_full};
            default:    bus_rdata = '0;
        endcase
        en_o      = q.en;
        net_o     = q.net;
        len_o     = q.len;
        tx_hold_o = q.hold;
        tx_full_o = q.tx_full;
        irq_rx    = q.rx_full;
        irq_tx    = q.en & ~q.tx_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ssp_slave.sv
module ssp_slave
    import ssp_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_rx,
    output logic              irq_tx,
    input  logic              sck_i,
    input  logic              fs_i,
    input  logic              pin_rx_i,
    output logic              pin_tx_o,
    input  logic              aud_txd_i,
    output logic              aud_rxd_o
);
    logic              bit_evt, frame_evt;
    logic              en_w, net_w;
    logic [1:0]        len_w;
    logic [DATA_W-1:0] tx_hold, rx_word;
    logic              tx_full, tx_take, rx_load, rx_tag, port_txd;

    ssp_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (sck_i),
        .fs_i        (fs_i),
        .bit_evt_o   (bit_evt),
        .frame_evt_o (frame_evt)
    );

    ssp_shift #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_w),
        .net_i       (net_w),
        .len_i       (len_w),
        .bit_evt_i   (bit_evt),
        .frame_evt_i (frame_evt),
        .rxd_i       (pin_rx_i),
        .tx_hold_i   (tx_hold),
        .tx_full_i   (tx_full),
        .txd_o       (port_txd),
        .rx_load_o   (rx_load),
        .rx_word_o   (rx_word),
        .rx_tag_o    (rx_tag),
        .tx_take_o   (tx_take)
    );

    ssp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_load_i (rx_load),
        .rx_word_i (rx_word),
        .rx_tag_i  (rx_tag),
        .tx_take_i (tx_take),
        .en_o      (en_w),
        .net_o     (net_w),
        .len_o     (len_w),
        .tx_hold_o (tx_hold),
        .tx_full_o (tx_full),
        .irq_rx    (irq_rx),
        .irq_tx    (irq_tx)
    );

    // shared pins: port owns them while enabled
    always_comb begin
        pin_tx_o  = en_w ? port_txd : aud_txd_i;
        aud_rxd_o = en_w ? 1'b0 : pin_rx_i;
    end
endmodule

// File: rtl/ssp_slave_chk.sv
module ssp_slave_chk
    import ssp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sck_i,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              en,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic              pin_tx_o
);
    // R4: a receive interrupt appears only after a bit-clock edge
    assert_rx_irq_after_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> $past(sck_i));

    // R4: the receive interrupt drops only after an RXDATA read
    assert_rx_irq_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_rx) |-> $past(bus_rd && bus_addr == ADR_RXDATA));

    // R10: a disabled port never raises the receive interrupt
    assert_rx_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> $past(en));

    // R8: the transmit pin moves only after rising bit-clock edges
    assert_tx_stable_between_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bus_wr && !$rose(sck_i)) |=> $stable(pin_tx_o));

    // R8: the transmit interrupt drops only after a register write
    assert_tx_irq_clear_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_tx) |-> $past(bus_wr));

    // R8: the transmit interrupt rises on a word start or an enable write
    assert_tx_irq_set_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_tx) |-> ($past(sck_i) || $past(bus_wr)));
endmodule

bind ssp_slave ssp_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_i    (sck_i),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .en       (en_w),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx),
    .pin_tx_o (pin_tx_o)
);

// File: tb/sim_ssp_slave.sv
module sim_ssp_slave;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {len code[50:49], network[48], rx word[47:24], tx word[23:0]}
    localparam logic [50:0] VEC [0:NVEC-1] = '{
        {2'd0, 1'b0, 24'hFFC35A, 24'h1234A7},
        {2'd1, 1'b0, 24'h77BEEF, 24'h008001},
        {2'd2, 1'b0, 24'hC0FFEE, 24'h5A5A5A},
        {2'd3, 1'b0, 24'h123456, 24'h800001},
        {2'd0, 1'b1, 24'h000081, 24'h00007E},
        {2'd2, 1'b1, 24'h9ABCDE, 24'hF0F00F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [23:0] bus_wdata = '0;
    logic [23:0] bus_rdata;
    logic        irq_rx, irq_tx;
    logic        sck = 1'b0, fs = 1'b0, rxd = 1'b0, aud_txd = 1'b0;
    logic        pin_tx, aud_rxd;
    int          checks = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .sck_i(sck), .fs_i(fs),
        .pin_rx_i(rxd), .pin_tx_o(pin_tx), .aud_txd_i(aud_txd), .aud_rxd_o(aud_rxd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [23:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [23:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // one bit-clock period; t is the transmit pin just before the rising edge
    task automatic clock_bit(input logic b, input logic f, output logic t);
        @(negedge clk);
        sck = 1'b0; rxd = b; fs = f;
        repeat (3) @(negedge clk);
        t = pin_tx;
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic int lenof(input logic [1:0] c);
        return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 24;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [23:0] v, cap, mask;
        logic [71:0] cap72;
        logic        t;
        int          len;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, v); check("R1 ctrl", v, 0);
        bus_read(2'd3, v); check("R1 status", v, 2);
        check("R1 irq", {irq_rx, irq_tx}, 0);
        // R10 pass-through while disabled
        aud_txd = 1'b1; rxd = 1'b1; @(negedge clk);
        check("R10 tx pass", pin_tx, 1);
        check("R10 rx pass", aud_rxd, 1);
        aud_txd = 1'b0; @(negedge clk);
        check("R10 tx pass low", pin_tx, 0);

        // table of word lengths and modes: R2 R3 R4 R6 R8
        for (int k = 0; k < NVEC; k++) begin
            len  = lenof(VEC[k][50:49]);
            mask = ~(24'hFFFFFF << len);
            bus_write(2'd0, 24'h0);
            bus_write(2'd0, {20'h0, VEC[k][50:49], VEC[k][48], 1'b1});
            bus_write(2'd1, VEC[k][23:0]);
            check("R8 tx irq cleared by write", irq_tx, 0);
            cap = '0;
            for (int i = 0; i < len; i++) begin
                clock_bit(VEC[k][24 + len - 1 - i], i == 0, t);
                cap = {cap[22:0], t};
            end
            check("R4 irq_rx set", irq_rx, 1);
            clock_bit(1'b0, 1'b0, t);
            cap = {cap[22:0], t};
            bus_read(2'd3, v);
            check("R6 status tag/full", {29'h0, v[2], v[0]}, {29'h0, VEC[k][48], 1'b1});
            bus_read(2'd2, v);
            check("R2 R3 rx word", v, VEC[k][47:24] & mask);
            check("R4 irq_rx cleared", irq_rx, 0);
            check("R8 tx bits", cap & mask, VEC[k][23:0] & mask);
            check("R8 tx irq after move", irq_tx, 1);
        end

        // R5 normal mode ignores trailing bit clocks
        bus_write(2'd0, 24'h0);
        bus_write(2'd0, 24'h1);
        for (int i = 0; i < 8; i++) clock_bit(i[0], i == 0, t);
        bus_read(2'd2, v);
        check("R5 word", v, 24'h55);
        for (int i = 0; i < 10; i++) clock_bit(1'b1, 1'b0, t);
        bus_read(2'd3, v);
        check("R5 no further load", v[0], 0);

        // R7 frame sync in mid-word restarts
        for (int i = 0; i < 4; i++) clock_bit(~i[0], i == 0, t);
        for (int i = 0; i < 8; i++) clock_bit(((8'h6C >> (7 - i)) & 1) != 0, i == 0, t);
        bus_read(2'd2, v);
        check("R7 restarted word", v, 24'h6C);

        // R9 underrun sends zeros
        bus_read(2'd3, v);
        check("R9 holding empty", v[1], 1);
        cap = '0;
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1, i == 0, t);
            cap = {cap[22:0], t};
        end
        check("R9 zero word", cap & 24'hFF, 0);
        bus_read(2'd2, v);

        // R6 network packet with refills: three 8-bit words
        bus_write(2'd0, 24'h0);
        bus_write(2'd0, 24'h3);
        bus_write(2'd1, 24'hC1);
        cap72 = '0;
        for (int w = 0; w < 3; w++) begin
            for (int i = 0; i < 8; i++) begin
                clock_bit((((8'h11 * (w + 1)) >> (7 - i)) & 1) != 0, (w == 0) && (i == 0), t);
                cap72 = {cap72[70:0], t};
                if (i == 0 && w == 0) bus_write(2'd1, 24'h5E);
                if (i == 0 && w == 1) bus_write(2'd1, 24'h3A);
            end
            bus_read(2'd3, v);
            check("R6 packet tag", v[2], (w == 0) ? 1 : 0);
            bus_read(2'd2, v);
            check("R6 packet word", v, 24'(8'h11 * (w + 1)));
        end
        clock_bit(1'b0, 1'b0, t);
        cap72 = {cap72[70:0], t};
        check("R8 packet tx stream", cap72[23:0], 24'hC15E3A);

        // R10 disabled: nothing received, pins pass through; enabled blocks rx pass
        bus_write(2'd0, 24'h0);
        for (int i = 0; i < 8; i++) clock_bit(1'b1, i == 0, t);
        bus_read(2'd3, v);
        check("R10 no receive when disabled", v[0], 0);
        aud_txd = 1'b1; @(negedge clk);
        check("R10 tx pass again", pin_tx, 1);
        bus_write(2'd0, 24'h1);
        rxd = 1'b1; @(negedge clk);
        check("R10 rx blocked when enabled", aud_rxd, 0);
        check("R10 pin owned when enabled", pin_tx, 0);

        summary();
        $finish;
    end
endmodule